// File: doc/BRIEF.md
# Video AGC with Tuner Handoff

This block closes the gain loop for a demodulated composite video stream. During each line, two windows marked by external strobes select the samples that form a sync-tip average and a back-porch average. When the line strobe arrives, the block takes the difference of the two averages as the line's measured amplitude. It then compares that amplitude with a target word that software writes. The video gain word moves one step toward the target on the following cycle.

The video gain can fall to its floor while the signal is still too strong. The block then raises a tuner current code, one step per line, which tells an external tuner to reduce its own gain. The tuner code is only released once the video gain has climbed back to a hysteresis threshold, so the two loops never pull against each other.

In positive-modulation mode, the back-porch reference that the block reports is clamped to a band of 17% to 38% of the measured amplitude. Both gain words are outputs, so software can read them as a measure of signal strength.

Top module: `vidAgc`

## Requirements
- R1: A synchronous reset sets videoGain to midscale (2^(GW-1)) and sets tunerCode, measAmp and porchRef to zero.
- R2: Each window average is the sum of the first 2^AVG_LOG samples taken while that window is high, shifted right by AVG_LOG. If fewer samples arrive, the sum of those samples is still divided by 2^AVG_LOG. The following samples are not accumulated: those beyond the first 2^AVG_LOG in a window, those taken while both windows are low, and those taken in the lineStrobe cycle or the cycle after it.
- R3: On the clock edge that samples lineStrobe high, measAmp becomes the absolute difference between the sync-tip average (syncWin) and the back-porch average (porchWin). The new value is visible in the following cycle.
- R4: When posMod is high at the lineStrobe edge, porchRef becomes the back-porch average clamped between floor(measAmp*17/100) and floor(measAmp*38/100).
- R5: When posMod is low at the lineStrobe edge, porchRef becomes the unclamped back-porch average.
- R6: On the edge one cycle after the lineStrobe edge, videoGain changes as follows. If measAmp is greater than targetAmp and videoGain is not zero, it decreases by 1. If measAmp is less than targetAmp and no tuner release takes place (R8), it increases by 1, saturating at 2^GW-1. If measAmp equals targetAmp, it holds.
- R7: When measAmp is greater than targetAmp and videoGain is zero, tunerCode increases by 1 at that same edge, saturating at 2^TW-1.
- R8: When measAmp is less than targetAmp, tunerCode is non-zero and videoGain is at least HYST, tunerCode decreases by 1 and videoGain holds.
- R9: videoGain and tunerCode change only on the edge one cycle after a lineStrobe edge, by at most one step each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | SW | Composite video sample, unsigned |
| syncWin | input | 1 | High while samples belong to the sync-tip window |
| porchWin | input | 1 | High while samples belong to the back-porch window |
| lineStrobe | input | 1 | One-cycle end-of-line pulse |
| posMod | input | 1 | Positive-modulation mode, enables the porch clamp |
| targetAmp | input | SW | Target amplitude register |
| videoGain | output | GW | Video gain word |
| tunerCode | output | TW | Tuner AGC current code |
| measAmp | output | SW | Last measured line amplitude |
| porchRef | output | SW | Last back-porch reference, clamped in positive mode |

## Verification
The hardest situation to reach from the ports is tuner release. To get there, the video gain must first be driven from midscale to zero, the tuner code must be pushed up to saturation, and the gain must then climb back past the hysteresis threshold before the tuner code can fall. The bench reaches it with long directed runs of strong-signal lines followed by weak-signal lines, and checks every line against a model of both loops. Seeded random lines with varied windows, levels, modes and targets then cover clamping, partial windows and overlong windows.

// File: rtl/agcPkg.sv
package agcPkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // latch this line's measurement
    logic clear;    // zero the window accumulators
  } agcStb_t;
endpackage

// File: rtl/agcDatapath.sv
module agcDatapath
  import agcPkg::*;
#(
  parameter int SW      = 10,
  parameter int AVG_LOG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  agcStb_t       stb,
  input  logic [SW-1:0] sample,
  input  logic          syncWin,
  input  logic          porchWin,
  input  logic          posMod,
  output logic [SW-1:0] measAmp,
  output logic [SW-1:0] porchRef
);
  localparam int NAVG = 1 << AVG_LOG;
  localparam int AW   = SW + AVG_LOG;
  localparam int CW   = AVG_LOG + 1;
  localparam int PW   = SW + 7;

  logic [1:0]    winHit;
  logic [SW-1:0] avg [2];

  // Sync window wins when both are raised.
  assign winHit[0] = syncWin;
  assign winHit[1] = porchWin & ~syncWin;

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic [AW-1:0] sum;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst || stb.clear) begin
        sum <= '0;
        cnt <= '0;
      end else if (!stb.capture && winHit[w] && cnt < CW'(NAVG)) begin
        sum <= sum + AW'(sample);
        cnt <= cnt + 1'b1;
      end
    end

    assign avg[w] = sum[AW-1:AVG_LOG];

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(NAVG));
  end

  logic [SW-1:0] ampNow, loBound, hiBound, refNow;
  logic          posModQ;

  always_comb begin
    ampNow  = (avg[0] >= avg[1]) ? avg[0] - avg[1] : avg[1] - avg[0];
    loBound = SW'((PW'(ampNow) * PW'(17)) / PW'(100));
    hiBound = SW'((PW'(ampNow) * PW'(38)) / PW'(100));
    refNow  = avg[1];
    if (posMod) begin
      if (avg[1] > hiBound)      refNow = hiBound;
      else if (avg[1] < loBound) refNow = loBound;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      measAmp  <= '0;
      porchRef <= '0;
      posModQ  <= 1'b0;
    end else if (stb.capture) begin
      measAmp  <= ampNow;
      porchRef <= refNow;
      posModQ  <= posMod;
    end
  end

  a_r4_upper: assert property (@(posedge clk) disable iff (rst)
    posModQ |-> (PW'(porchRef) * PW'(100) <= PW'(measAmp) * PW'(38)));
  a_r4_lower: assert property (@(posedge clk) disable iff (rst)
    posModQ |-> ((PW'(porchRef) + PW'(1)) * PW'(100) > PW'(measAmp) * PW'(17)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.capture |=> $stable(measAmp) && $stable(porchRef));
endmodule

// File: rtl/agcCtrl.sv
module agcCtrl
  import agcPkg::*;
#(
  parameter int SW   = 10,
  parameter int GW   = 8,
  parameter int TW   = 6,
  parameter int HYST = 144
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lineStrobe,
  input  logic [SW-1:0] measAmp,
  input  logic [SW-1:0] targetAmp,
  output agcStb_t       stb,
  output logic [GW-1:0] videoGain,
  output logic [TW-1:0] tunerCode
);
  localparam logic [GW-1:0] GMAX   = {GW{1'b1}};
  localparam logic [GW-1:0] GMID   = GW'(1) << (GW - 1);
  localparam logic [TW-1:0] TMAX   = {TW{1'b1}};
  localparam logic [GW-1:0] HYST_C = GW'(HYST);

  logic stepQ;

  always_comb begin
    stb.capture = lineStrobe;
    stb.clear   = stepQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ     <= 1'b0;
      videoGain <= GMID;
      tunerCode <= '0;
    end else begin
      stepQ <= lineStrobe;
      if (stepQ) begin
        if (measAmp > targetAmp) begin
          if (videoGain != '0)        videoGain <= videoGain - 1'b1;
          else if (tunerCode != TMAX) tunerCode <= tunerCode + 1'b1;
        end else if (measAmp < targetAmp) begin
          if (tunerCode != '0 && videoGain >= HYST_C) tunerCode <= tunerCode - 1'b1;
          else if (videoGain != GMAX)                 videoGain <= videoGain + 1'b1;
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !stepQ |=> $stable(videoGain) && $stable(tunerCode));
  a_r9_one_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (videoGain == $past(videoGain) ||
                     videoGain == $past(videoGain) + 1'b1 ||
                     videoGain == $past(videoGain) - 1'b1));
  a_r7_tuner_up_at_floor: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tunerCode > $past(tunerCode)) |-> $past(videoGain) == '0);
  a_r8_release_above_hyst: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tunerCode < $past(tunerCode)) |->
      ($past(videoGain) >= HYST_C && videoGain == $past(videoGain)));
endmodule

// File: rtl/vidAgc.sv
module vidAgc
  import agcPkg::*;
#(
  parameter int SW      = 10,
  parameter int GW      = 8,
  parameter int TW      = 6,
  parameter int AVG_LOG = 2,
  parameter int HYST    = 144
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sample,
  input  logic          syncWin,
  input  logic          porchWin,
  input  logic          lineStrobe,
  input  logic          posMod,
  input  logic [SW-1:0] targetAmp,
  output logic [GW-1:0] videoGain,
  output logic [TW-1:0] tunerCode,
  output logic [SW-1:0] measAmp,
  output logic [SW-1:0] porchRef
);
  agcStb_t stb;

  agcCtrl #(.SW(SW), .GW(GW), .TW(TW), .HYST(HYST)) i_ctrl (
    .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .measAmp(measAmp),
    .targetAmp(targetAmp), .stb(stb), .videoGain(videoGain), .tunerCode(tunerCode)
  );

  agcDatapath #(.SW(SW), .AVG_LOG(AVG_LOG)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .sample(sample), .syncWin(syncWin),
    .porchWin(porchWin), .posMod(posMod), .measAmp(measAmp), .porchRef(porchRef)
  );
endmodule

// File: tb/test_vidAgc.sv
module test_vidAgc;
  localparam int SW = 10, GW = 8, TW = 6, AVG_LOG = 2, HYST = 144;
  localparam int GMAX = (1 << GW) - 1, TMAX = (1 << TW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [SW-1:0] sample = '0, targetAmp = '0;
  logic syncWin = 1'b0, porchWin = 1'b0, lineStrobe = 1'b0, posMod = 1'b0;
  logic [GW-1:0] videoGain;
  logic [TW-1:0] tunerCode;
  logic [SW-1:0] measAmp, porchRef;

  int checks = 0, errors = 0;
  int eg = 1 << (GW - 1), et = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vidAgc #(.SW(SW), .GW(GW), .TW(TW), .AVG_LOG(AVG_LOG), .HYST(HYST)) i_vidAgc (
    .clk(clk), .rst(rst), .sample(sample), .syncWin(syncWin), .porchWin(porchWin),
    .lineStrobe(lineStrobe), .posMod(posMod), .targetAmp(targetAmp),
    .videoGain(videoGain), .tunerCode(tunerCode), .measAmp(measAmp), .porchRef(porchRef)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Drives n samples in one window; returns the sum of the first four.
  task automatic feedWindow(input bit isSync, input int n, input int level,
                            input int jitter, output int sum4);
    sum4 = 0;
    for (int i = 0; i < n; i++) begin
      int s;
      @(negedge clk);
      s = level + ((jitter > 0) ? int'($urandom_range(0, jitter)) : 0);
      sample = SW'(s);
      syncWin = isSync;
      porchWin = !isSync;
      if (i < (1 << AVG_LOG)) sum4 += s;
    end
    @(negedge clk);
    syncWin = 1'b0;
    porchWin = 1'b0;
    sample = SW'($urandom_range(0, 1023));  // stray, outside windows
  endtask

  function automatic int clampRef(input int pa, input int amp, input bit pm);
    int lo = (amp * 17) / 100;
    int hi = (amp * 38) / 100;
    if (!pm) return pa;
    if (pa > hi) return hi;
    if (pa < lo) return lo;
    return pa;
  endfunction

  task automatic runLine(input int sLvl, input int nS, input int pLvl, input int nP,
                         input bit pm, input int tgt, input int jit);
    int ss, ps, sa, pa, amp, expRef, oldG, oldT;
    posMod = pm;
    targetAmp = SW'(tgt);
    feedWindow(1'b1, nS, sLvl, jit, ss);
    feedWindow(1'b0, nP, pLvl, jit, ps);
    sa = ss >> AVG_LOG;
    pa = ps >> AVG_LOG;
    amp = (sa >= pa) ? sa - pa : pa - sa;
    expRef = clampRef(pa, amp, pm);
    oldG = eg;
    oldT = et;
    @(negedge clk);
    lineStrobe = 1'b1;
    sample = SW'($urandom_range(0, 1023));
    @(negedge clk);
    lineStrobe = 1'b0;
    // Capture done, step not yet: gains must still hold (R9)
    check("R9 gain before step", int'(videoGain), oldG);
    check("R9 tuner before step", int'(tunerCode), oldT);
    if (amp > tgt) begin
      if (eg != 0) eg--;
      else if (et != TMAX) et++;
    end else if (amp < tgt) begin
      if (et != 0 && eg >= HYST) et--;
      else if (eg != GMAX) eg++;
    end
    @(negedge clk);
    check("R2/R3 measAmp", int'(measAmp), amp);
    check(pm ? "R4 porchRef clamp" : "R5 porchRef raw", int'(porchRef), expRef);
    check("R6/R8 videoGain", int'(videoGain), eg);
    check("R7/R8 tunerCode", int'(tunerCode), et);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset videoGain", int'(videoGain), 1 << (GW - 1));
    check("R1 reset tunerCode", int'(tunerCode), 0);
    check("R1 reset measAmp", int'(measAmp), 0);
    check("R1 reset porchRef", int'(porchRef), 0);

    // Equal amplitude holds gain; porch above upper bound (R4, R6)
    runLine(100, 4, 400, 4, 1'b1, 300, 0);
    // Porch below lower bound in positive mode (R4)
    runLine(900, 4, 100, 4, 1'b1, 300, 0);
    // Same levels in negative mode: no clamp (R5)
    runLine(900, 4, 100, 4, 1'b0, 300, 0);
    // Partial and overlong windows (R2)
    runLine(200, 2, 600, 7, 1'b0, 300, 5);
    runLine(50, 9, 700, 3, 1'b1, 300, 5);

    // Strong signal: gain to floor, then tuner up to saturation (R6, R7)
    for (int k = 0; k < 210; k++) runLine(50, 4, 600, 4, 1'b0, 300, 3);
    check("R7 tuner saturated", int'(tunerCode), TMAX);
    // Weak signal: gain climbs to HYST, tuner releases, gain saturates (R8, R6)
    for (int k = 0; k < 330; k++) runLine(300, 4, 400, 4, 1'b0, 300, 3);
    check("R8 tuner released", int'(tunerCode), 0);
    check("R6 gain saturated", int'(videoGain), GMAX);

    // Constrained random lines
    for (int k = 0; k < 300; k++) begin
      runLine(int'($urandom_range(0, 1000)), int'($urandom_range(1, 6)),
              int'($urandom_range(0, 1000)), int'($urandom_range(1, 6)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, 1023)), 15);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-chain act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule